// File: doc/BRIEF.md
# Signed Sequential Shift-Add Multiplier

This block multiplies two two's-complement integers of `WIDTH` bits (40 by default) and leaves the full signed product, `2*WIDTH` bits wide, in a double-length accumulator. It works one multiplier bit per clock. It begins with the most significant bit and doubles the accumulator before each conditional add of the multiplicand. No shifted copies of the multiplicand are kept.

Both operands are first treated as unsigned words. Signs are handled by two correction steps that run before the loop starts. A negative multiplier contributes minus the multiplicand, and a negative multiplicand contributes minus the multiplier. Each correction enters the accumulator at the weight that the following `WIDTH` doublings carry up to bit `WIDTH`, which is the low bit of the upper half. The corrections must happen before the multiplier register starts shifting, because shifting discards the multiplier's sign bit. The loop counter is a one-hot word: its bit moves up one place per pass, and the loop ends after the pass taken with the top bit set.

A one-cycle `start_i` pulse latches the operands while the block is idle. `busy_o` stays high during the computation. `done_o` pulses for one cycle, and the product then holds on `product_o` until the next accepted start.

Top module: `signed_shift_mul`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: For any two signed `WIDTH`-bit operands, `product_o` at `done_o` equals their exact signed product as a `2*WIDTH`-bit two's-complement value.
- R3: `done_o` is first seen high exactly `WIDTH+3` clock cycles after the edge that accepts `start_i`. That is two correction cycles, `WIDTH` loop cycles and one finish cycle. During the loop the counter holds exactly one set bit.
- R4: `busy_o` is high in the cycle after an accepted start and stays high until `done_o` is raised. It is low while `done_o` is high.
- R5: A `start_i` pulse while `busy_o` is high is ignored. The running operation keeps its operands and its latency.
- R6: While `busy_o` is low and no start is given, `product_o` does not change.
- R7: Operands at the most negative value, at zero and at minus one give correct products. This holds in particular when both sign corrections apply together.
- R8: `done_o` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when not busy |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2*WIDTH | Signed product, held after completion |

## Verification
A 5-bit instance is swept over all 1024 operand pairs. Every combination of sign corrections is exercised, with no correction, one correction or both, including the most negative value times itself, where both corrections wrap. The 40-bit default instance gets the corner operands most negative, zero, minus one and plus one in all pairings, plus random operands. These separate a missing or misweighted correction from a wrong loop count. Separate runs inject a start mid-operation and idle for several cycles after completion, which shows whether ignored starts or stray accumulator writes disturb the held result.

// File: rtl/shift_mul_pkg.sv
package shift_mul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CORR_R,
    ST_CORR_D,
    ST_LOOP,
    ST_DONE
  } mul_state_e;
endpackage

// File: rtl/shift_mul_ctrl.sv
module shift_mul_ctrl
  import shift_mul_pkg::*;
#(
  parameter int WIDTH = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic corr_r_o,
  output logic corr_d_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  mul_state_e state_q, state_d;
  logic [WIDTH-1:0] cnt_q;
  logic last_pass;

  assign last_pass = cnt_q[WIDTH-1];
  assign busy_o    = (state_q == ST_CORR_R) || (state_q == ST_CORR_D) || (state_q == ST_LOOP);
  assign done_o    = (state_q == ST_DONE);
  assign load_o    = start_i && !busy_o;
  assign corr_r_o  = (state_q == ST_CORR_R);
  assign corr_d_o  = (state_q == ST_CORR_D);
  assign step_o    = (state_q == ST_LOOP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: state_d = start_i ? ST_CORR_R : ST_IDLE;
      ST_CORR_R:        state_d = ST_CORR_D;
      ST_CORR_D:        state_d = ST_LOOP;
      ST_LOOP:          state_d = last_pass ? ST_DONE : ST_LOOP;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CORR_D)    cnt_q <= {{(WIDTH-1){1'b0}}, 1'b1};
      else if (state_q == ST_LOOP) cnt_q <= cnt_q << 1;
    end
  end

  // R3
  cnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOP) |-> ($countones(cnt_q) == 1));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R5
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(step_o && last_pass)) |=> busy_o);
endmodule

// File: rtl/shift_mul_dp.sv
module shift_mul_dp #(
  parameter int WIDTH = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               corr_r_i,
  input  logic               corr_d_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] acc_o
);
  localparam int AW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q, mreg_q;
  logic [AW-1:0]    acc_q, acc_d, add_term;

  // corrections enter at bit 0; WIDTH doublings lift them to bit WIDTH
  always_comb begin
    acc_d    = acc_q;
    add_term = '0;
    if (corr_r_i && mreg_q[WIDTH-1])
      acc_d = acc_q - {{WIDTH{1'b0}}, mcand_q};
    else if (corr_d_i && mcand_q[WIDTH-1])
      acc_d = acc_q - {{WIDTH{1'b0}}, mreg_q};
    else if (step_i) begin
      if (mreg_q[WIDTH-1]) add_term = {{WIDTH{1'b0}}, mcand_q};
      acc_d = {acc_q[AW-2:0], 1'b0} + add_term;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      mreg_q  <= '0;
      acc_q   <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      mreg_q  <= mplier_i;
      acc_q   <= '0;
    end else begin
      acc_q <= acc_d;
      if (step_i) mreg_q <= mreg_q << 1;
    end
  end

  assign acc_o = acc_q;

  // R5
  mcand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mcand_q));
endmodule

// File: rtl/signed_shift_mul.sv
module signed_shift_mul #(
  parameter int WIDTH = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic load, corr_r, corr_d, step;

  shift_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .load_o   (load),
    .corr_r_o (corr_r),
    .corr_d_o (corr_d),
    .step_o   (step),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  shift_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .corr_r_i (corr_r),
    .corr_d_i (corr_d),
    .step_i   (step),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .acc_o    (product_o)
  );

  // R6
  product_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));

  // R4
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/signed_shift_mul_bench.sv
module signed_shift_mul_bench;
  localparam int W  = 40;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0, mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  logic            s_start = 1'b0;
  logic [SW-1:0]   s_mcand = '0, s_mplier = '0;
  logic            s_busy, s_done;
  logic [2*SW-1:0] s_product;

  int n_vec = 0;
  int n_bad = 0;

  signed_shift_mul #(.WIDTH(W)) u_signed_shift_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mcand_i(mcand), .mplier_i(mplier),
    .busy_o(busy), .done_o(done), .product_o(product)
  );

  signed_shift_mul #(.WIDTH(SW)) u_signed_shift_mul_small (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .mcand_i(s_mcand), .mplier_i(s_mplier),
    .busy_o(s_busy), .done_o(s_done), .product_o(s_product)
  );

  task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] ea, eb;
    ea = $signed({{W{a[W-1]}}, a});
    eb = $signed({{W{b[W-1]}}, b});
    return ea * eb;
  endfunction

  // full run on the wide instance; optional stray start at cycle k_stray
  task automatic run_wide(input logic [W-1:0] a, input logic [W-1:0] b, input int k_stray);
    int k;
    logic [2*W-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; k = 1;
    check(busy === 1'b1, "R4 busy after start", {79'd0, busy}, 80'd1);
    while (done !== 1'b1 && k < 200) begin
      if (k == k_stray) begin
        mcand = ~a; mplier = b + 40'd3; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(k == W + 3, "R3 latency", k, W + 3);
    check(busy === 1'b0, "R4 busy low at done", {79'd0, busy}, 80'd0);
    check(product === exp, k_stray > 0 ? "R5 stray start ignored" : "R2 product", product, exp);
    @(negedge clk);
    check(done === 1'b0, "R8 done pulse width", {79'd0, done}, 80'd0);
  endtask

  task automatic run_small(input logic [SW-1:0] a, input logic [SW-1:0] b);
    int k;
    logic signed [2*SW-1:0] exp;
    exp = $signed({{SW{a[SW-1]}}, a}) * $signed({{SW{b[SW-1]}}, b});
    @(negedge clk);
    s_mcand = a; s_mplier = b; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0; k = 1;
    while (s_done !== 1'b1 && k < 50) begin
      @(negedge clk);
      k++;
    end
    check(s_product === exp && k == SW + 3, "R2 exhaustive small",
          {70'd0, s_product}, {70'd0, exp});
  endtask

  initial begin
    #(10 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] corner [4];
    logic [2*W-1:0] held;
    corner[0] = {1'b1, {(W-1){1'b0}}};
    corner[1] = '0;
    corner[2] = '1;
    corner[3] = 40'd1;

    #23;
    check(busy === 1'b0 && done === 1'b0, "R1 reset flags", {78'd0, busy, done}, 80'd0);
    check(product === '0, "R1 reset product", product, 80'd0);
    rst_n = 1'b1;

    // R7 corner pairings, both corrections at most-negative squared
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        run_wide(corner[i], corner[j], 0);
    check(product === ref_mul(corner[3], corner[3]), "R7 corner last", product,
          ref_mul(corner[3], corner[3]));
    run_wide(corner[0], corner[0], 0);
    check(product === {2'b01, {(2*W-2){1'b0}}}, "R7 min times min", product,
          {2'b01, {(2*W-2){1'b0}}});

    for (int n = 0; n < 120; n++)
      run_wide({$urandom, $urandom}, {$urandom, $urandom}, 0);

    // R5 stray start mid-operation
    run_wide(40'h80_1234_5678, 40'h7F_FEDC_BA98, 7);
    run_wide(40'hFF_FFFF_FFFE, 40'h80_0000_0001, 30);

    // R6 held result while idle
    held = product;
    repeat (6) @(negedge clk);
    check(product === held, "R6 product held while idle", product, held);

    for (int a = 0; a < (1 << SW); a++)
      for (int b = 0; b < (1 << SW); b++)
        run_small(a[SW-1:0], b[SW-1:0]);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule